// File: doc/BRIEF.md
# Atomic Byte Read-Modify-Write Unit

This unit performs one indivisible read-modify-write on a single byte of data memory. The byte is chosen by a pointer address. An operation starts when a start strobe arrives with a valid operation code. In the first cycle the unit reads the byte at the pointer. In the second cycle it writes back a merged value and hands the old byte to the register file. A lock output stays high across both cycles, so an outside arbiter can keep every other requester off the memory port while the operation is in flight.

Three merges are supported. Exchange stores the register operand. Set-bits stores the operand OR the old byte. Clear-bits stores the old byte AND the complement of the operand. In every case the register receives the unmodified old byte. The unit has no flag outputs and never changes the pointer. The pointer and operand are captured when the start is accepted, so the caller may change them while an operation runs. A new start may be presented in the write cycle of the previous operation, and the next read then follows without a gap.

Top module: `atomic_rmw_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_rd_o, mem_wr_o, lock_o, done_o and reg_we_o are all low.
- R2: A start with op_i in {0,1,2}, accepted when idle or in a write cycle, makes the next cycle a read cycle: mem_rd_o high, mem_wr_o low, mem_addr_o equal to ptr_i as sampled with the start.
- R3: Every read cycle is followed by exactly one write cycle: mem_wr_o, done_o and reg_we_o high, mem_rd_o low, and mem_addr_o unchanged from the read cycle.
- R4: With op code 0 (exchange), mem_wdata_o in the write cycle equals the captured operand.
- R5: With op code 1 (set-bits), mem_wdata_o equals the captured operand OR the byte returned by the read.
- R6: With op code 2 (clear-bits), mem_wdata_o equals the complement of the captured operand AND the byte returned by the read.
- R7: In every write cycle, reg_wdata_o equals the old byte returned on mem_rdata_i for that read.
- R8: lock_o is high in every read and write cycle and low in every other cycle.
- R9: A start with op code 3 starts no operation: no read cycle follows it.
- R10: A start presented during a read cycle is ignored: the next cycle is that operation's write cycle, and no extra read follows it.
- R11: A start accepted in a write cycle produces a read cycle in the very next cycle, and lock_o stays high across the transition.
- R12: Changes on ptr_i, reg_i and op_i after acceptance have no effect on the address, the write data or the returned byte of the operation already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Operation request strobe |
| op_i | input | 2 | 0 exchange, 1 set-bits, 2 clear-bits, 3 reserved |
| ptr_i | input | ADDR_W | Byte address held by the pointer |
| reg_i | input | DATA_W | Register operand |
| mem_rd_o | output | 1 | Memory read enable (read cycle) |
| mem_wr_o | output | 1 | Memory write enable (write cycle) |
| mem_addr_o | output | ADDR_W | Memory address, held across both cycles |
| mem_wdata_o | output | DATA_W | Merged byte written back |
| mem_rdata_i | input | DATA_W | Read data, valid in the cycle after mem_rd_o |
| lock_o | output | 1 | Memory held for the atomic sequence |
| reg_we_o | output | 1 | Register write enable |
| reg_wdata_o | output | DATA_W | Old memory byte returned to the register |
| done_o | output | 1 | Operation completes this cycle |

## Verification
A new request can be accepted in the same cycle that the previous operation writes its merged byte and returns its old value. The bench provokes this overlap on purpose. It issues back-to-back starts, often at the same pointer, so the second read must observe the byte that the first write has just stored. A bench shadow memory, updated only at the write cycles it predicts, supplies the expected old byte and merged value. Every cycle is also checked for the read, write and lock levels against a phase model kept by the bench. Starts presented during read cycles and starts with the reserved code are mixed in randomly to test that both kinds are rejected.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    RMW_XCHG = 2'd0,
    RMW_SET  = 2'd1,
    RMW_CLR  = 2'd2,
    RMW_RSVD = 2'd3
  } rmw_op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } rmw_phase_e;

  function automatic logic op_is_valid(input logic [OP_W-1:0] op);
    return (op != RMW_RSVD);
  endfunction

  // Single-bit merge rule shared by every lane.
  function automatic logic merge_bit(input logic [OP_W-1:0] op,
                                     input logic opnd,
                                     input logic old);
    logic r;
    unique case (op)
      RMW_XCHG: r = opnd;
      RMW_SET:  r = opnd | old;
      RMW_CLR:  r = ~opnd & old;
      default:  r = old;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rmw_sequencer.sv
module rmw_sequencer
  import atomic_rmw_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [OP_W-1:0] op_i,
  output logic            accept_o,
  output logic            rd_o,
  output logic            wr_o,
  output logic            lock_o,
  output logic            done_o,
  output logic            reg_we_o
);

  rmw_phase_e phase_q, phase_n;
  logic       rd_q, wr_q, lock_q, done_q, rwe_q;
  logic       can_take;

  // A request may enter while idle or while the previous write drains.
  assign can_take = (phase_q == PH_IDLE) || (phase_q == PH_WRITE);
  assign accept_o = start_i && op_is_valid(op_i) && can_take;

  always_comb begin
    phase_n = phase_q;
    unique case (phase_q)
      PH_IDLE:  phase_n = accept_o ? PH_READ : PH_IDLE;
      PH_READ:  phase_n = PH_WRITE;
      PH_WRITE: phase_n = accept_o ? PH_READ : PH_IDLE;
      default:  phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      lock_q  <= 1'b0;
      done_q  <= 1'b0;
      rwe_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      rd_q    <= (phase_n == PH_READ);
      wr_q    <= (phase_n == PH_WRITE);
      lock_q  <= (phase_n != PH_IDLE);
      done_q  <= (phase_n == PH_WRITE);
      rwe_q   <= (phase_n == PH_WRITE);
    end
  end

  assign rd_o     = rd_q;
  assign wr_o     = wr_q;
  assign lock_o   = lock_q;
  assign done_o   = done_q;
  assign reg_we_o = rwe_q;

endmodule

// File: rtl/rmw_capture.sv
module rmw_capture
  import atomic_rmw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] opnd_o,
  output logic [OP_W-1:0]   op_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opnd_q;
  logic [OP_W-1:0]   op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      opnd_q <= '0;
      op_q   <= RMW_XCHG;
    end else if (load_i) begin
      addr_q <= ptr_i;
      opnd_q <= opnd_i;
      op_q   <= op_i;
    end
  end

  assign addr_o = addr_q;
  assign opnd_o = opnd_q;
  assign op_o   = op_q;

endmodule

// File: rtl/rmw_merge.sv
module rmw_merge
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] old_i,
  output logic [DATA_W-1:0] new_o
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    assign new_o[b] = merge_bit(op_i, opnd_i[b], old_i[b]);
  end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              lock_o,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              done_o
);

  logic              accept;
  logic [OP_W-1:0]   cap_op;
  logic [DATA_W-1:0] cap_opnd;
  logic [DATA_W-1:0] merged;

  rmw_sequencer u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .op_i     (op_i),
    .accept_o (accept),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o),
    .lock_o   (lock_o),
    .done_o   (done_o),
    .reg_we_o (reg_we_o)
  );

  rmw_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .ptr_i  (ptr_i),
    .opnd_i (reg_i),
    .op_i   (op_i),
    .addr_o (mem_addr_o),
    .opnd_o (cap_opnd),
    .op_o   (cap_op)
  );

  rmw_merge #(.DATA_W(DATA_W)) u_merge (
    .op_i   (cap_op),
    .opnd_i (cap_opnd),
    .old_i  (mem_rdata_i),
    .new_o  (merged)
  );

  assign mem_wdata_o = mem_wr_o ? merged : '0;
  assign reg_wdata_o = reg_we_o ? mem_rdata_i : '0;

endmodule

// File: rtl/atomic_rmw_checker.sv
module atomic_rmw_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              lock_o,
  input logic              done_o,
  input logic              reg_we_o
);

  // R2: a valid start outside a read cycle opens a read cycle
  a_r2_read_follows_start: assert property (@(posedge clk) disable iff (rst)
    (start_i && op_i != 2'd3 && !mem_rd_o) |=> mem_rd_o);

  // R3: each read is followed by a completing write
  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |=> (mem_wr_o && done_o && reg_we_o && !mem_rd_o));

  // R3: the address holds from read to write
  a_r3_addr_held: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |=> $stable(mem_addr_o));

  // R8: lock covers exactly the access cycles
  a_r8_lock_span: assert property (@(posedge clk) disable iff (rst)
    lock_o == (mem_rd_o || mem_wr_o));

  // R9: reserved code never opens a read from idle
  a_r9_reserved_dropped: assert property (@(posedge clk) disable iff (rst)
    (start_i && op_i == 2'd3 && !lock_o) |=> !mem_rd_o);

  // R10: no back-to-back reads
  a_r10_no_double_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |=> !mem_rd_o);

  // R3: a write cycle is never entered without a read before it
  a_r3_write_needs_read: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_o) |-> $past(mem_rd_o));

endmodule

bind atomic_rmw_unit atomic_rmw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .op_i       (op_i),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_addr_o (mem_addr_o),
  .lock_o     (lock_o),
  .done_o     (done_o),
  .reg_we_o   (reg_we_o)
);

// File: tb/atomic_rmw_unit_tb_top.sv
`timescale 1ns/1ps
module atomic_rmw_unit_tb_top;

  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = 2'd0;
  logic [AW-1:0] ptr_i = '0;
  logic [DW-1:0] reg_i = '0;
  logic          mem_rd_o, mem_wr_o, lock_o, reg_we_o, done_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, reg_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;

  always #2 clk = ~clk;

  atomic_rmw_unit #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .ptr_i(ptr_i),
    .reg_i(reg_i), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .lock_o(lock_o), .reg_we_o(reg_we_o),
    .reg_wdata_o(reg_wdata_o), .done_o(done_o)
  );

  // Synchronous byte memory beside the unit
  logic [DW-1:0] ram [256];
  logic [DW-1:0] shadow [256];

  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata_i <= ram[mem_addr_o[7:0]];
    if (mem_wr_o) ram[mem_addr_o[7:0]] <= mem_wdata_o;
  end

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Bench phase model: 0 idle, 1 read, 2 write
  int            ph = 0;
  logic [AW-1:0] e_addr = '0;
  logic [1:0]    e_op = 2'd0;
  logic [DW-1:0] e_opnd = '0;

  function automatic logic [DW-1:0] expect_new(input logic [1:0] op,
                                               input logic [DW-1:0] opnd,
                                               input logic [DW-1:0] old);
    case (op)
      2'd0:    return opnd;
      2'd1:    return opnd | old;
      2'd2:    return ~opnd & old;
      default: return old;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Check the current cycle, drive the next request, advance the model.
  task automatic step(input logic st, input logic [1:0] op,
                      input logic [AW-1:0] p, input logic [DW-1:0] v);
    logic          acc;
    logic [DW-1:0] old;
    string         wtag;
    chk("R2_R8 rd", mem_rd_o, ph == 1);
    chk("R3 wr", mem_wr_o, ph == 2);
    chk("R8 lock", lock_o, ph != 0);
    chk("R3 done", done_o, ph == 2);
    chk("R3 reg_we", reg_we_o, ph == 2);
    if (ph != 0) chk("R2_R12 addr", mem_addr_o, e_addr);
    if (ph == 2) begin
      old = shadow[e_addr[7:0]];
      wtag = (e_op == 2'd0) ? "R4 xchg" : (e_op == 2'd1) ? "R5 set" : "R6 clr";
      chk(wtag, mem_wdata_o, expect_new(e_op, e_opnd, old));
      chk("R7 old", reg_wdata_o, old);
      shadow[e_addr[7:0]] = expect_new(e_op, e_opnd, old);
    end
    start_i = st; op_i = op; ptr_i = p; reg_i = v;
    acc = st && (op != 2'd3) && (ph != 1);
    if (ph == 1) ph = 2;
    else if (acc) begin
      ph = 1; e_addr = p; e_op = op; e_opnd = v;
    end else ph = 0;
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_1234);
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'(i * 37 + 5);
      shadow[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    // R1: reset holds all controls low
    chk("R1 rd", mem_rd_o, 0); chk("R1 wr", mem_wr_o, 0);
    chk("R1 lock", lock_o, 0); chk("R1 done", done_o, 0);
    chk("R1 reg_we", reg_we_o, 0);
    rst = 1'b0;
    @(negedge clk);
    // R4 / R5 / R6 directed, each isolated
    step(1, 2'd0, 16'h0010, 8'hA5); step(0, 2'd1, 16'hFFFF, 8'h00); step(0, 0, 0, 0);
    step(1, 2'd1, 16'h0010, 8'h0F); step(0, 2'd2, 16'h1234, 8'hFF); step(0, 0, 0, 0);
    step(1, 2'd2, 16'h0010, 8'h81); step(0, 0, 0, 0); step(0, 0, 0, 0);
    // R9: reserved code
    step(1, 2'd3, 16'h0020, 8'h55); step(0, 0, 0, 0);
    // R10: start during read cycle is dropped
    step(1, 2'd1, 16'h0030, 8'hF0); step(1, 2'd0, 16'h0031, 8'h11);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    // R11: back-to-back at the same address, with R12 input churn
    step(1, 2'd0, 16'h0040, 8'h3C); step(0, 2'd2, 16'h0099, 8'hEE);
    step(1, 2'd1, 16'h0040, 8'hC0); step(0, 2'd0, 16'h0077, 8'h01);
    step(1, 2'd2, 16'h0140, 8'h0C); step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    // Constrained random traffic over few addresses
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] p;
      p = {8'($urandom), 4'h0, 4'($urandom)};
      step(1'($urandom % 2), 2'($urandom), p, 8'($urandom));
    end
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule